// File: doc/BRIEF.md
# TDM Signalling Channel Serial Receiver

The block watches a time-division multiplexed serial stream and picks signalling bits from one selected timeslot. Each frame it takes 1, 2 or 8 bits from that timeslot. It packs those bits into bytes and places the bytes in a small receive FIFO, which the host drains through a valid/ready read port. The line idles at 1. The receiver can run in one of three ways:

- **Unframed:** the raw bits are packed eight at a time.
- **Byte-framed:** each character is a 0 start bit, eight data bits, an optional parity bit and a stop bit.
- **Message-framed:** a single start bit is followed by a programmed number of payload bits (1 to 256), an optional parity bit and a stop bit.

In the framed modes the start, stop and parity bits are stripped, so only payload reaches the FIFO. In message mode a final byte that holds fewer than eight payload bits is zero-padded. The first received bit of each byte lands in D0 or in D7, as the bit-order control selects.

Status is kept simple. A sticky error flag reports a parity mismatch or a stop bit received as 0. The interrupt line works in one of two ways: in FIFO-level mode it follows a fill threshold, and in message mode it is set when a message completes. A status-read strobe clears both the error flag and the message-complete interrupt. On the read port, `rd_data` is valid while `rd_valid` is high. A byte is popped on any clock edge where `rd_valid` and `rd_ready` are both high. While `rd_ready` stays low the head byte is held unchanged. There is no back-pressure towards the line: a byte completed while the FIFO is full is discarded.

Top module: `sig_rx`

## Requirements
- R1: Bits are taken only from timeslot `cfg_slot` (8 bit times per slot, slot 0 begins at the bit marked by `fsync`). Only the first 1, 2 or 8 bit times of that slot are used, for `cfg_rate` = 0, 1 or 2/3 respectively. All other bit times are ignored.
- R2: With `cfg_msg_mode`=0 and `cfg_framed`=0, every 8 taken bits form one FIFO byte, and `cfg_par_en` has no effect.
- R3: With `cfg_msg_mode`=0 and `cfg_framed`=1, the receiver ignores idle 1s and waits for a 0 start bit. It then takes 8 data bits, a parity bit if `cfg_par_en`=1, and a stop bit. Only the data byte is written to the FIFO.
- R4: With `cfg_msg_mode`=1, `cfg_framed` is ignored. After a 0 start bit, `cfg_msg_len` payload bits (1..256) are packed into bytes, followed by an optional parity bit and a stop bit. A final partial byte is zero-padded in the bit positions after the last payload bit.
- R5: With `cfg_msb_first`=0 the first bit of each byte goes to D0. With `cfg_msb_first`=1 it goes to D7.
- R6: Parity is even, so the parity bit equals the XOR of the payload bits. A parity mismatch, or a stop bit of 0, sets `err_flag`. The flag stays set until a `stat_rd` pulse clears it.
- R7: The FIFO holds 16 bytes and delivers them in order. A pop happens on `rd_valid && rd_ready`. `rd_valid` is high exactly when `fifo_level` is nonzero. A byte completed while the FIFO is full is dropped.
- R8: With `cfg_msg_mode`=0, `irq` is high while `fifo_level >= cfg_level`. With `cfg_msg_mode`=1, `irq` is set when a message's stop bit is received and is cleared by `stat_rd`.
- R9: While `cfg_en`=0 no bit is taken, and the framer is returned to hunting for a start bit.
- R10: After reset the FIFO is empty and `irq` and `err_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle strobe per line bit time |
| fsync | input | 1 | Marks the first bit time of a frame (valid with bit_en) |
| sdata | input | 1 | Serial line data, sampled with bit_en |
| cfg_en | input | 1 | Receiver enable |
| cfg_msg_mode | input | 1 | 1: message framing, 0: FIFO-level mode |
| cfg_framed | input | 1 | Start/stop framing in FIFO-level mode |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_msb_first | input | 1 | First bit lands in D7 |
| cfg_rate | input | 2 | Bits per frame: 0→1, 1→2, 2/3→8 |
| cfg_slot | input | 2 | Selected timeslot |
| cfg_msg_len | input | 9 | Payload bits per message, 1..256 |
| cfg_level | input | 5 | FIFO fill threshold for irq |
| stat_rd | input | 1 | Status read strobe, clears err_flag and message irq |
| rd_valid | output | 1 | FIFO head byte valid |
| rd_ready | input | 1 | Host accepts the head byte |
| rd_data | output | 8 | FIFO head byte |
| fifo_level | output | 5 | Bytes held in the FIFO |
| err_flag | output | 1 | Sticky parity/stop error |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a line bit that belongs to the selected channel arriving exactly when the receiver is meant to see it, amid the filler bits of the other timeslots. The bench handles this with a background frame generator. It fills every other timeslot with 0s, which would look like start bits if any leaked through. Selected-channel bits are drawn from a queue, so each scenario only queues its bit sequence and waits for the queue to drain. In unframed mode the idle 1s would themselves form bytes. To stop this, the generator raises `cfg_en` only while queued bits are flowing, which also exercises the disable path.

// File: rtl/sig_rx_pkg.sv
package sig_rx_pkg;
  typedef enum logic [1:0] {
    FR_HUNT = 2'd0,
    FR_DATA = 2'd1,
    FR_PAR  = 2'd2,
    FR_STOP = 2'd3
  } fr_state_e;

  function automatic logic [3:0] rate_bits(input logic [1:0] code);
    case (code)
      2'd0:    rate_bits = 4'd1;
      2'd1:    rate_bits = 4'd2;
      default: rate_bits = 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/sig_slot_tap.sv
module sig_slot_tap #(
  parameter int SLOTS = 4,
  localparam int CW = $clog2(SLOTS * 8),
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          fsync,
  input  logic          sdata,
  input  logic          en,
  input  logic [1:0]    rate,
  input  logic [SW-1:0] slot,
  output logic          tap_vld,
  output logic          tap_bit
);
  import sig_rx_pkg::*;

  logic [CW-1:0] pos_q;
  logic [CW-1:0] cur;
  logic          take;

  assign cur  = fsync ? '0 : pos_q;
  assign take = (cur[CW-1:3] == slot) && ({1'b0, cur[2:0]} < rate_bits(rate));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      tap_vld <= 1'b0;
      tap_bit <= 1'b1;
    end else begin
      tap_vld <= bit_en && en && take;
      if (bit_en) begin
        pos_q   <= cur + 1'b1;
        tap_bit <= sdata;
      end
    end
  end
endmodule

// File: rtl/sig_deframer.sv
module sig_deframer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       in_vld,
  input  logic       in_bit,
  input  logic       msg_mode,
  input  logic       framed,
  input  logic       par_en,
  input  logic       msb_first,
  input  logic [8:0] msg_len,
  output logic       push_vld,
  output logic [7:0] push_data,
  output logic       err_set,
  output logic       msg_done
);
  import sig_rx_pkg::*;

  fr_state_e  st;
  logic [7:0] sh;
  logic [7:0] sh_nx;
  logic [2:0] nb;
  logic [8:0] cnt;
  logic [8:0] cnt_nx;
  logic [8:0] len;
  logic       par;
  logic       use_frame;

  assign use_frame = msg_mode || framed;
  assign len       = msg_mode ? msg_len : 9'd8;
  assign cnt_nx    = cnt + 9'd1;
  assign sh_nx     = msb_first ? {sh[6:0], in_bit} : {in_bit, sh[7:1]};

  function automatic logic [7:0] align(input logic [7:0] v, input logic [2:0] k_m1,
                                       input logic msb);
    logic [2:0] gap;
    gap = 3'd7 - k_m1;
    align = msb ? (v << gap) : (v >> gap);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= FR_HUNT;
      sh        <= '0;
      nb        <= '0;
      cnt       <= '0;
      par       <= 1'b0;
      push_vld  <= 1'b0;
      push_data <= '0;
      err_set   <= 1'b0;
      msg_done  <= 1'b0;
    end else begin
      push_vld <= 1'b0;
      err_set  <= 1'b0;
      msg_done <= 1'b0;
      if (!en) begin
        st <= FR_HUNT;
        nb <= '0;
      end else if (in_vld) begin
        if (!use_frame) begin
          sh <= sh_nx;
          nb <= nb + 3'd1;
          if (nb == 3'd7) begin
            push_vld  <= 1'b1;
            push_data <= sh_nx;
          end
        end else begin
          case (st)
            FR_HUNT: if (!in_bit) begin
              st  <= FR_DATA;
              nb  <= '0;
              cnt <= '0;
              par <= 1'b0;
              sh  <= '0;
            end
            FR_DATA: begin
              sh  <= sh_nx;
              par <= par ^ in_bit;
              cnt <= cnt_nx;
              nb  <= nb + 3'd1;
              if (nb == 3'd7 || cnt_nx == len) begin
                push_vld  <= 1'b1;
                push_data <= align(sh_nx, nb, msb_first);
                nb        <= '0;
                sh        <= '0;
              end
              if (cnt_nx == len) st <= par_en ? FR_PAR : FR_STOP;
            end
            FR_PAR: begin
              if (in_bit != par) err_set <= 1'b1;
              st <= FR_STOP;
            end
            default: begin
              if (!in_bit) err_set <= 1'b1;
              msg_done <= msg_mode;
              st       <= FR_HUNT;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/sig_byte_fifo.sv
module sig_byte_fifo #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_vld,
  input  logic [7:0]    wr_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [7:0]    rd_data,
  output logic [LW-1:0] level
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_wr, do_rd;

  assign rd_valid = (level != '0);
  assign rd_data  = mem[rp];
  assign do_rd    = rd_valid && rd_ready;
  assign do_wr    = wr_vld && (level != LW'(DEPTH));

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      level <= level + LW'(do_wr) - LW'(do_rd);
    end
  end
endmodule

// File: rtl/sig_rx.sv
module sig_rx #(
  parameter int SLOTS = 4,
  parameter int DEPTH = 16,
  localparam int SW = $clog2(SLOTS),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          fsync,
  input  logic          sdata,
  input  logic          cfg_en,
  input  logic          cfg_msg_mode,
  input  logic          cfg_framed,
  input  logic          cfg_par_en,
  input  logic          cfg_msb_first,
  input  logic [1:0]    cfg_rate,
  input  logic [SW-1:0] cfg_slot,
  input  logic [8:0]    cfg_msg_len,
  input  logic [LW-1:0] cfg_level,
  input  logic          stat_rd,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [7:0]    rd_data,
  output logic [LW-1:0] fifo_level,
  output logic          err_flag,
  output logic          irq
);
  logic       tap_vld, tap_bit;
  logic       push_vld, err_set, msg_done;
  logic [7:0] push_data;
  logic       msg_flag;

  sig_slot_tap #(.SLOTS(SLOTS)) u_tap (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync), .sdata(sdata),
    .en(cfg_en), .rate(cfg_rate), .slot(cfg_slot),
    .tap_vld(tap_vld), .tap_bit(tap_bit)
  );

  sig_deframer u_fr (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .in_vld(tap_vld), .in_bit(tap_bit),
    .msg_mode(cfg_msg_mode), .framed(cfg_framed), .par_en(cfg_par_en),
    .msb_first(cfg_msb_first), .msg_len(cfg_msg_len),
    .push_vld(push_vld), .push_data(push_data), .err_set(err_set), .msg_done(msg_done)
  );

  sig_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_vld(push_vld), .wr_data(push_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .level(fifo_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      msg_flag <= 1'b0;
    end else begin
      err_flag <= (err_flag && !stat_rd) || err_set;
      msg_flag <= (msg_flag && !stat_rd) || msg_done;
    end
  end

  assign irq = cfg_msg_mode ? msg_flag : (fifo_level >= cfg_level);
endmodule

// File: rtl/sig_rx_chk.sv
module sig_rx_chk #(
  parameter int LW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_en,
  input logic          cfg_msg_mode,
  input logic [LW-1:0] cfg_level,
  input logic          stat_rd,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [7:0]    rd_data,
  input logic [LW-1:0] fifo_level,
  input logic          err_flag,
  input logic          irq
);
  assert_valid_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == (fifo_level != '0));

  assert_head_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  assert_level_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level <= $past(fifo_level) + 1'b1) && (fifo_level + 1'b1 >= $past(fifo_level)));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !stat_rd |=> err_flag);

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_msg_mode && fifo_level == '0 && cfg_level != '0 |-> !irq);

  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_en) && !$past(cfg_en, 2) |-> fifo_level <= $past(fifo_level));
endmodule

bind sig_rx sig_rx_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_msg_mode(cfg_msg_mode),
  .cfg_level(cfg_level), .stat_rd(stat_rd), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .fifo_level(fifo_level), .err_flag(err_flag), .irq(irq)
);

// File: tb/test_sig_rx.sv
`timescale 1ns/1ps
module test_sig_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en, fsync, sdata;
  logic cfg_en, cfg_msg_mode, cfg_framed, cfg_par_en, cfg_msb_first;
  logic [1:0] cfg_rate, cfg_slot;
  logic [8:0] cfg_msg_len;
  logic [4:0] cfg_level;
  logic stat_rd = 1'b0;
  logic rd_ready = 1'b0;
  logic rd_valid, err_flag, irq;
  logic [7:0] rd_data;
  logic [4:0] fifo_level;

  int checks = 0;
  int fails = 0;
  logic tb_en = 1'b0;
  logic drv_en = 1'b0;
  logic gate = 1'b0;
  logic q [1024];
  int qw = 0;
  int qr = 0;
  int rate_n = 8;

  always #2.5 clk = ~clk;
  assign cfg_en = gate ? drv_en : tb_en;
  assign cfg_slot = 2'd2;

  sig_rx i_sig_rx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync), .sdata(sdata),
    .cfg_en(cfg_en), .cfg_msg_mode(cfg_msg_mode), .cfg_framed(cfg_framed),
    .cfg_par_en(cfg_par_en), .cfg_msb_first(cfg_msb_first), .cfg_rate(cfg_rate),
    .cfg_slot(cfg_slot), .cfg_msg_len(cfg_msg_len), .cfg_level(cfg_level),
    .stat_rd(stat_rd), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .fifo_level(fifo_level), .err_flag(err_flag), .irq(irq)
  );

  // frame generator: other slots carry 0s, selected slot carries queued bits or idle 1s
  initial begin
    sdata = 1'b1; bit_en = 1'b0; fsync = 1'b0;
    wait (rst_n);
    forever begin
      for (int i = 0; i < 32; i++) begin
        @(negedge clk);
        if (i / 8 == 2 && i % 8 < rate_n) begin
          if (qr != qw) begin
            sdata = q[qr % 1024]; qr++; drv_en = 1'b1;
          end else begin
            sdata = 1'b1; drv_en = 1'b0;
          end
        end else sdata = 1'b0;
        bit_en = 1'b1; fsync = (i == 0);
        @(negedge clk);
        bit_en = 1'b0; fsync = 1'b0;
        repeat (2) @(negedge clk);
      end
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic qbit(input logic b);
    q[qw % 1024] = b; qw++;
  endtask

  task automatic qbits(input logic [7:0] v, input int n, input logic msb);
    for (int k = 0; k < n; k++) qbit(msb ? v[7 - k] : v[k]);
  endtask

  task automatic qchar(input logic [7:0] v, input logic msb, input logic pen,
                       input logic pbit, input logic stop);
    qbit(1'b0); qbits(v, 8, msb);
    if (pen) qbit(pbit);
    qbit(stop);
  endtask

  task automatic drain();
    wait (qr == qw);
    repeat (300) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pop_exp(input logic [7:0] exp, input string req);
    @(negedge clk);
    chk(rd_valid && rd_data == exp, req, rd_data, exp);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic stat_pulse();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic m, input logic f, input logic p, input logic msb,
                         input int rate);
    cfg_msg_mode = m; cfg_framed = f; cfg_par_en = p; cfg_msb_first = msb;
    rate_n = rate;
    cfg_rate = (rate == 1) ? 2'd0 : (rate == 2) ? 2'd1 : 2'd2;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!rd_valid && fifo_level == 0, "R10 empty", fifo_level, 0);
    chk(!irq && !err_flag, "R10 flags", {irq, err_flag}, 0);
  endtask

  task automatic t_unframed();
    set_cfg(0, 0, 1, 0, 8); gate = 1'b1;
    qbits(8'hA5, 8, 0); qbits(8'h3C, 8, 0);
    drain();
    chk(fifo_level == 2, "R2 count", fifo_level, 2);
    pop_exp(8'hA5, "R2/R5 lsb first byte0");
    pop_exp(8'h3C, "R2 byte1");
    chk(!err_flag, "R2 parity ignored", err_flag, 0);
    gate = 1'b0;
  endtask

  task automatic t_byte_msb_par();
    set_cfg(0, 1, 1, 1, 2); tb_en = 1'b1;
    qchar(8'h96, 1, 1, 1'b0, 1'b1);
    drain();
    chk(fifo_level == 1, "R3 one byte", fifo_level, 1);
    pop_exp(8'h96, "R3/R5 msb first");
    chk(!err_flag, "R6 good parity", err_flag, 0);
  endtask

  task automatic t_byte_rate1();
    set_cfg(0, 1, 0, 0, 1);
    qbit(1'b1); qbit(1'b1);
    qchar(8'h5A, 0, 0, 1'b0, 1'b1);
    drain();
    chk(fifo_level == 1, "R1 rate1 other slots ignored", fifo_level, 1);
    pop_exp(8'h5A, "R1 rate1 data");
  endtask

  task automatic t_errors();
    set_cfg(0, 1, 1, 0, 8);
    qchar(8'h96, 0, 1, 1'b1, 1'b1);
    drain();
    chk(err_flag, "R6 parity error", err_flag, 1);
    pop_exp(8'h96, "R6 data kept");
    stat_pulse();
    chk(!err_flag, "R6 cleared", err_flag, 0);
    set_cfg(0, 1, 0, 0, 8);
    qchar(8'h11, 0, 0, 1'b0, 1'b0);
    qbit(1'b1);
    drain();
    chk(err_flag, "R6 stop error", err_flag, 1);
    pop_exp(8'h11, "R6 stop data");
    stat_pulse();
  endtask

  task automatic t_msg12();
    set_cfg(1, 0, 1, 0, 8); cfg_msg_len = 9'd12;
    qbit(1'b0); qbits(8'hC3, 8, 0); qbits(8'h09, 4, 0); qbit(1'b0); qbit(1'b1);
    drain();
    chk(fifo_level == 2, "R4 two bytes", fifo_level, 2);
    chk(irq, "R8 msg irq", irq, 1);
    chk(!err_flag, "R6 msg parity", err_flag, 0);
    pop_exp(8'hC3, "R4 full byte");
    pop_exp(8'h09, "R4 padded lsb");
    stat_pulse();
    chk(!irq, "R8 irq cleared", irq, 0);
  endtask

  task automatic t_msg_other();
    set_cfg(1, 1, 0, 1, 8); cfg_msg_len = 9'd24;
    qbit(1'b0); qbits(8'h12, 8, 1); qbits(8'h34, 8, 1); qbits(8'h56, 8, 1); qbit(1'b1);
    drain();
    chk(fifo_level == 3, "R4 24-bit message", fifo_level, 3);
    pop_exp(8'h12, "R4 b0"); pop_exp(8'h34, "R4 b1"); pop_exp(8'h56, "R4 b2");
    stat_pulse();
    cfg_msg_len = 9'd1;
    qbit(1'b0); qbit(1'b1); qbit(1'b1);
    drain();
    pop_exp(8'h80, "R4/R5 one-bit message msb");
    chk(irq, "R8 short msg irq", irq, 1);
    stat_pulse();
  endtask

  task automatic t_disable();
    set_cfg(0, 1, 0, 0, 8); tb_en = 1'b0;
    qchar(8'h77, 0, 0, 1'b0, 1'b1);
    drain();
    chk(fifo_level == 0, "R9 disabled ignores", fifo_level, 0);
    tb_en = 1'b1;
    qchar(8'h42, 0, 0, 1'b0, 1'b1);
    drain();
    pop_exp(8'h42, "R9 re-enabled");
  endtask

  task automatic t_level_full();
    set_cfg(0, 0, 0, 0, 8); gate = 1'b1; cfg_level = 5'd3;
    qbits(8'h01, 8, 0); qbits(8'h02, 8, 0);
    drain();
    chk(!irq, "R8 below threshold", irq, 0);
    qbits(8'h03, 8, 0);
    drain();
    chk(irq, "R8 at threshold", irq, 1);
    for (int v = 4; v <= 18; v++) qbits(8'(v), 8, 0);
    drain();
    chk(fifo_level == 16, "R7 full", fifo_level, 16);
    for (int v = 1; v <= 16; v++) pop_exp(8'(v), "R7 order/drop");
    chk(!rd_valid, "R7 empty after", rd_valid, 0);
    gate = 1'b0;
  endtask

  initial begin
    set_cfg(0, 0, 0, 0, 8); cfg_msg_len = 9'd8; cfg_level = 5'd1;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unframed();
    t_byte_msb_par();
    t_byte_rate1();
    t_errors();
    t_msg12();
    t_msg_other();
    t_disable();
    t_level_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule